// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block supplies the data-hazard control for a five-stage in-order integer pipeline. It has fetch, decode/register-read, execute, memory and writeback stages. In every cycle it compares the register numbers read by the instructions in decode and execute with the destinations of the instructions further down the pipe.

From those comparisons it produces two outputs. The first is a pair of operand-source selects that steer the ALU inputs to a result still in flight. The second is a stall that holds the fetch and decode stages and turns the decode-to-execute transfer into a no-op.

The register file is assumed to write early in a cycle and read late in the same cycle. A producer that has reached writeback while its consumer is in decode is therefore served by the register file. No path through this block is needed for it. A load cannot hand its data to an instruction directly behind it, so that pair always costs one bubble. After the bubble, the consumer collects the loaded value from the memory/writeback latch. The block keeps one register: it remembers that execute holds an inserted bubble, so that the bubble's leftover source fields steer nothing.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 takes the register file, 2'b01 the memory/writeback latch (instruction in writeback), 2'b10 the execute/memory latch (instruction in memory). The code 2'b11 never appears. An execute source equal to the memory-stage destination, with that write enable high, selects 2'b10.
- R2: An execute source equal to the writeback-stage destination, with that write enable high and no memory-stage match, selects 2'b01.
- R3: When both the memory-stage and writeback-stage destinations match the same source, the memory-stage (younger) result wins with 2'b10.
- R4: Register 0 never forwards and never stalls, whatever the destinations and flags.
- R5: A producer whose write enable is low never forwards and never causes a stall, even if it is flagged as a load.
- R6: A load in execute with write enable high and a nonzero destination equal to either decode source raises hold_pc, hold_ifid and bubble_idex together in that same cycle.
- R7: A non-load producer in execute never causes a stall.
- R8: In the cycle after bubble_idex was high, both operand selects are 2'b00 whatever the execute sources are.
- R9: After the load-use bubble, the consumer reaches execute with the load in writeback and selects 2'b01 for the loaded register.
- R10: A source matching no in-flight destination selects 2'b00. This includes a producer three instructions ahead, which has already left writeback.
- R11: A synchronous active-low reset clears the bubble memory. With no producers in flight, all outputs are low.
- R12: A load-use pair stalls for exactly one cycle. With the bubble in execute, the held consumer is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs_a | input | RIDX_W | First source register of the decode instruction |
| id_rs_b | input | RIDX_W | Second source register of the decode instruction |
| ex_rs_a | input | RIDX_W | First source register of the execute instruction |
| ex_rs_b | input | RIDX_W | Second source register of the execute instruction |
| ex_rd | input | RIDX_W | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | RIDX_W | Destination held in the execute/memory latch |
| mem_wen | input | 1 | Write enable held in the execute/memory latch |
| wb_rd | input | RIDX_W | Destination held in the memory/writeback latch |
| wb_wen | input | 1 | Write enable held in the memory/writeback latch |
| fwd_sel_a | output | 2 | Source select for ALU operand A |
| fwd_sel_b | output | 2 | Source select for ALU operand B |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the fetch/decode latch |
| bubble_idex | output | 1 | Load a no-op into the decode/execute latch |

## Verification
The selects and the stall are combinational, so they are due in the same cycle as the register numbers that cause them. The bench changes inputs on the falling edge and samples 2 ns later, well before the next rising edge. The only delayed result is the suppression after a bubble, due one rising edge after bubble_idex was high. The bench carries its own flag across that edge and applies it to the next sample. A cycle-level pipeline model in the bench moves random instructions through decode, execute, memory and writeback, inserting bubbles with stale source fields. This exercises back-to-back loads, chained dependences and the one-cycle release.

// File: rtl/hfu_pkg.sv
// Shared types for the hazard forwarding unit.
// Assumes a two-bit operand-source code consumed by the ALU input muxes.
package hfu_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE   = 2'b00,
        SRC_WB_LATCH  = 2'b01,
        SRC_MEM_LATCH = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/hfu_operand_sel.sv
// Operand source selector for one ALU input.
// Compares the execute-stage source with the destinations in the memory and
// writeback latches; the memory latch holds the younger result and wins.
// Assumes register 0 is hard-wired zero and a low write enable marks a
// non-writing instruction. 'suppress' forces the register file path.
module hfu_operand_sel
    import hfu_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic [RIDX_W-1:0] src,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic              wb_wen,
    input  logic              suppress,
    output opnd_src_e         sel
);
    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Qualify the two candidate producers.
    always_comb begin
        src_live = (src != '0) && !suppress;
        hit_mem  = src_live && mem_wen && (mem_rd == src);
        hit_wb   = src_live && wb_wen && (wb_rd == src);
    end

    // Younger producer first, then the older one, else the register file.
    always_comb begin
        if (hit_mem) begin
            sel = SRC_MEM_LATCH;
        end else if (hit_wb) begin
            sel = SRC_WB_LATCH;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/hfu_load_interlock.sv
// Load-use detector for the decode stage.
// Raises 'stall' when the execute instruction is a writing load whose nonzero
// destination is read by any decode source. Assumes all NUM_SRC sources are
// real reads when nonzero.
module hfu_load_interlock #(
    parameter int RIDX_W  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][RIDX_W-1:0] id_src,
    input  logic [RIDX_W-1:0]              ex_rd,
    input  logic                           ex_wen,
    input  logic                           ex_is_load,
    output logic                           stall
);
    logic [NUM_SRC-1:0] src_hit;
    logic               producer_ok;

    // A load that writes a real register can block a reader.
    always_comb producer_ok = ex_wen && ex_is_load && (ex_rd != '0);

    // One comparator per decode source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        always_comb src_hit[g] = (id_src[g] == ex_rd);
    end

    // Stall if the load feeds any decode source.
    always_comb stall = producer_ok && (|src_hit);
endmodule

// File: rtl/hfu_bubble_track.sv
// Remembers that the decode/execute latch was loaded with a bubble.
// The bubble keeps the held instruction's source fields, so the flag is used
// to keep those stale fields from steering the operand muxes.
// Synchronous active-low reset.
module hfu_bubble_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bubble_in,
    output logic bubble_in_ex
);
    // Capture the bubble request at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bubble_in_ex <= 1'b0;
        end else begin
            bubble_in_ex <= bubble_in;
        end
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Data-hazard control for a five-stage in-order integer pipeline.
// Produces ALU operand-source selects for the execute instruction and a
// load-use stall for fetch and decode. Assumes the register file writes in
// the first half-cycle and reads in the second, and that reads happen in
// decode and writes in writeback only, so only read-after-write needs care.
module hazard_fwd_unit
    import hfu_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] id_rs_a,
    input  logic [RIDX_W-1:0] id_rs_b,
    input  logic [RIDX_W-1:0] ex_rs_a,
    input  logic [RIDX_W-1:0] ex_rs_b,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              hold_pc,
    output logic              hold_ifid,
    output logic              bubble_idex
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][RIDX_W-1:0] id_src;
    logic [NUM_SRC-1:0][RIDX_W-1:0] ex_src;
    opnd_src_e [NUM_SRC-1:0]        ex_sel;
    logic                           load_use;
    logic                           ex_holds_bubble;

    // Gather the per-operand register numbers.
    always_comb begin
        id_src[0] = id_rs_a;
        id_src[1] = id_rs_b;
        ex_src[0] = ex_rs_a;
        ex_src[1] = ex_rs_b;
    end

    hfu_load_interlock #(
        .RIDX_W (RIDX_W),
        .NUM_SRC(NUM_SRC)
    ) u_interlock (
        .id_src    (id_src),
        .ex_rd     (ex_rd),
        .ex_wen    (ex_wen),
        .ex_is_load(ex_is_load),
        .stall     (load_use)
    );

    hfu_bubble_track u_bubble (
        .clk         (clk),
        .rst_n       (rst_n),
        .bubble_in   (load_use),
        .bubble_in_ex(ex_holds_bubble)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        hfu_operand_sel #(
            .RIDX_W(RIDX_W)
        ) u_sel (
            .src     (ex_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .suppress(ex_holds_bubble),
            .sel     (ex_sel[g])
        );
    end

    // Drive the pipeline control outputs.
    always_comb begin
        fwd_sel_a   = ex_sel[0];
        fwd_sel_b   = ex_sel[1];
        hold_pc     = load_use;
        hold_ifid   = load_use;
        bubble_idex = load_use;
    end
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
// Property checker for hazard_fwd_unit, attached with bind below.
module hazard_fwd_unit_chk
    import hfu_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int RIDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RIDX_W-1:0] id_rs_a,
    input logic [RIDX_W-1:0] id_rs_b,
    input logic [RIDX_W-1:0] ex_rs_a,
    input logic [RIDX_W-1:0] ex_rs_b,
    input logic [RIDX_W-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [RIDX_W-1:0] mem_rd,
    input logic              mem_wen,
    input logic [RIDX_W-1:0] wb_rd,
    input logic              wb_wen,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              hold_pc,
    input logic              hold_ifid,
    input logic              bubble_idex
);
    AST_SEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11)); // R1

    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && wb_wen && mem_rd == ex_rs_a && wb_rd == ex_rs_a && fwd_sel_a != 2'b00)
        |-> fwd_sel_a == SRC_MEM_LATCH); // R3

    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs_a == '0) |-> (fwd_sel_a == SRC_REGFILE)); // R4

    AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !hold_pc); // R4

    AST_NOWRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_wen |-> !bubble_idex); // R5

    AST_LOAD_USE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_wen && ex_rd != '0 && (id_rs_a == ex_rd || id_rs_b == ex_rd))
        |-> (hold_pc && hold_ifid && bubble_idex)); // R6

    AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !hold_ifid); // R7

    AST_BUBBLE_STEERS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex |=> (fwd_sel_a == SRC_REGFILE && fwd_sel_b == SRC_REGFILE)); // R8
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rs_a    (id_rs_a),
    .id_rs_b    (id_rs_b),
    .ex_rs_a    (ex_rs_a),
    .ex_rs_b    (ex_rs_b),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .mem_rd     (mem_rd),
    .mem_wen    (mem_wen),
    .wb_rd      (wb_rd),
    .wb_wen     (wb_wen),
    .fwd_sel_a  (fwd_sel_a),
    .fwd_sel_b  (fwd_sel_b),
    .hold_pc    (hold_pc),
    .hold_ifid  (hold_ifid),
    .bubble_idex(bubble_idex)
);

// File: tb/hazard_fwd_unit_tb.sv
// Bench for hazard_fwd_unit: directed corner cases, then a random
// instruction stream through a cycle-level pipeline model.
module hazard_fwd_unit_tb;
    localparam int NREG = 32;
    localparam int RW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_rs_a = '0, id_rs_b = '0, ex_rs_a = '0, ex_rs_b = '0;
    logic [RW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          hold_pc, hold_ifid, bubble_idex;

    int n_cmp = 0;
    int n_bad = 0;
    logic after_bub = 1'b0;

    always #5 clk = ~clk;

    hazard_fwd_unit #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_idex(bubble_idex)
    );

    // Expected select from the requirements (codes of R1).
    function automatic logic [1:0] want_sel(logic [RW-1:0] s, logic [RW-1:0] mr, logic mw,
                                            logic [RW-1:0] wr, logic ww, logic bub);
        if (bub || s == '0) return 2'b00;
        if (mw && mr == s)  return 2'b10;
        if (ww && wr == s)  return 2'b01;
        return 2'b00;
    endfunction

    // Expected load-use stall from the requirements.
    function automatic logic want_stall(logic [RW-1:0] ia, logic [RW-1:0] ib,
                                        logic [RW-1:0] er, logic ew, logic el);
        return el && ew && (er != '0) && (ia == er || ib == er);
    endfunction

    task automatic check(string tag, string what, logic [2:0] got, logic [2:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, sample 2 ns later, carry the
    // bubble flag across the next rising edge.
    task automatic cyc(string tag,
                       logic [RW-1:0] ia, logic [RW-1:0] ib,
                       logic [RW-1:0] xa, logic [RW-1:0] xb,
                       logic [RW-1:0] xr, logic xw, logic xl,
                       logic [RW-1:0] mr, logic mw,
                       logic [RW-1:0] wr, logic ww);
        logic st;
        @(negedge clk);
        id_rs_a = ia; id_rs_b = ib; ex_rs_a = xa; ex_rs_b = xb;
        ex_rd = xr; ex_wen = xw; ex_is_load = xl;
        mem_rd = mr; mem_wen = mw; wb_rd = wr; wb_wen = ww;
        #2;
        st = want_stall(ia, ib, xr, xw, xl);
        check(tag, "sel_a", {1'b0, fwd_sel_a}, {1'b0, want_sel(xa, mr, mw, wr, ww, after_bub)});
        check(tag, "sel_b", {1'b0, fwd_sel_b}, {1'b0, want_sel(xb, mr, mw, wr, ww, after_bub)});
        check(tag, "stall", {hold_pc, hold_ifid, bubble_idex}, {3{st}});
        after_bub = rst_n ? st : 1'b0;
    endtask

    typedef struct packed {
        logic [RW-1:0] sa;
        logic [RW-1:0] sb;
        logic [RW-1:0] rd;
        logic          we;
        logic          ld;
    } instr_t;

    function automatic instr_t rand_instr();
        instr_t t;
        t.sa = RW'($urandom_range(0, 7));
        t.sb = RW'($urandom_range(0, 7));
        t.rd = RW'($urandom_range(0, 7));
        t.we = ($urandom_range(0, 9) < 8);
        t.ld = ($urandom_range(0, 9) < 3);
        return t;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        instr_t p_id, p_ex, p_mem, p_wb;
        void'($urandom(32'd20240611));
        // Reset state (R11).
        repeat (2) @(posedge clk);
        cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc("R11", 3, 4, 5, 6, 0, 0, 0, 0, 0, 0, 0);
        // Memory-latch forward on operand A (R1).
        cyc("R1", 1, 2, 5, 6, 9, 1, 0, 5, 1, 0, 0);
        // Writeback-latch forward on operand B (R2).
        cyc("R2", 1, 2, 3, 7, 9, 1, 0, 4, 1, 7, 1);
        // Both latches hit the same register: younger wins (R3).
        cyc("R3", 1, 2, 9, 9, 8, 1, 0, 9, 1, 9, 1);
        // Register 0 never forwards or stalls (R4).
        cyc("R4", 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
        // Write enable low: no forward, no stall even for a load flag (R5).
        cyc("R5", 4, 4, 4, 4, 4, 0, 1, 4, 0, 4, 0);
        // Non-load producer feeding decode: no stall (R7).
        cyc("R7", 6, 2, 1, 1, 6, 1, 0, 0, 0, 0, 0);
        // No match and a producer three ahead gone: register file (R10).
        cyc("R10", 1, 2, 3, 3, 4, 1, 0, 2, 1, 1, 1);
        // Load-use sequence: stall (R6), bubble with stale sources (R8),
        // release (R12), consumer reads writeback latch (R9).
        cyc("R6", 5, 6, 1, 2, 6, 1, 1, 0, 0, 0, 0);
        cyc("R8", 5, 6, 5, 6, 0, 0, 0, 6, 1, 0, 0);
        check("R12", "released", {2'b00, hold_pc}, 3'b000);
        cyc("R9", 7, 1, 5, 6, 0, 0, 0, 0, 0, 6, 1);
        // Back-to-back loads on both decode sources (R6).
        cyc("R6", 3, 3, 0, 0, 3, 1, 1, 0, 0, 0, 0);
        cyc("R8", 3, 3, 3, 3, 0, 0, 0, 3, 1, 2, 1);

        // Random stream through the pipeline model.
        p_id = rand_instr(); p_ex = '0; p_mem = '0; p_wb = '0;
        for (int k = 0; k < 3000; k++) begin
            logic st;
            st = want_stall(p_id.sa, p_id.sb, p_ex.rd, p_ex.we, p_ex.ld);
            cyc("R6", p_id.sa, p_id.sb, p_ex.sa, p_ex.sb, p_ex.rd, p_ex.we, p_ex.ld,
                p_mem.rd, p_mem.we, p_wb.rd, p_wb.we);
            p_wb  = p_mem;
            p_mem = p_ex;
            if (st) begin
                p_ex    = p_id;
                p_ex.we = 1'b0;
                p_ex.ld = 1'b0;
            end else begin
                p_ex = p_id;
                p_id = rand_instr();
            end
        end
        finish_run();
    end
endmodule